// File: doc/BRIEF.md
# Processor Status and Register Bank Addressing Unit

This block keeps the 16-bit processor status word of a small 8-bit core. The upper byte holds a 5-bit register bank pointer. The lower byte holds the condition codes: half-carry, interrupt enable, a 2-bit interrupt level, negative, zero, overflow and carry. The ALU updates the arithmetic flags one at a time through per-flag write enables. Software loads the whole word with a single full write.

The unit maps a 3-bit register selector, taken from the low opcode bits, onto a 16-bit register-file address. That address lies in a fixed page, and the current bank pointer picks an 8-byte slot inside it. The unit also decides, combinationally, whether a pending interrupt request of a given level may be taken. When a request is taken, the new level is stored in the level field.

Top module: `proc_status_unit`

## Requirements
- R1: After a synchronous active-low reset, `ps_out` reads 0x0030. The bank pointer is 0, the level field is 3 and every other flag is 0.
- R2: The status word is laid out as bank pointer in bits 15..11, zeros in bits 10..8, and then H, I, level high, level low, N, Z, V, C in bits 7..0. When `ps_wr_en` is high, the word is loaded from `ps_wr_data` one cycle later, and bits 10..8 still read 0.
- R3: `reg_addr` equals 0x0100 + 8*bank pointer + `op_sel` at all times. It is combinational.
- R4: When `flag_we[4]` is high, H takes the value of `alu_half_carry` at the next edge.
- R5: When `flag_we[3]` is high, N takes bit 7 of `alu_result`.
- R6: When `flag_we[2]` is high, Z is set if `alu_result` is 0x00 and cleared otherwise.
- R7: When `flag_we[1]` is high, V takes `alu_ovf`. When `flag_we[0]` is high, C takes `alu_carry`.
- R8: A flag whose `flag_we` bit is low keeps its value, whatever the ALU inputs are.
- R9: `irq_accept` is high only when `irq_req` is high, I is 1, and `irq_level` is numerically smaller than the current level field. It is combinational.
- R10: On an edge where `irq_accept` is high, the level field is loaded with `irq_level` and I is unchanged. Flag updates on the same edge still take effect.
- R11: A full write overrides both the interrupt level load and the flag updates on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps_wr_en | input | 1 | Full status-word write strobe |
| ps_wr_data | input | 16 | Status word to write |
| alu_result | input | 8 | ALU result byte |
| alu_half_carry | input | 1 | Carry or borrow between bit 3 and bit 4 |
| alu_carry | input | 1 | ALU carry out |
| alu_ovf | input | 1 | ALU signed overflow |
| flag_we | input | 5 | Per-flag enables: 4=H, 3=N, 2=Z, 1=V, 0=C |
| op_sel | input | 3 | Low opcode bits selecting a register in the bank |
| reg_addr | output | 16 | Register-file address |
| irq_req | input | 1 | Interrupt request pending |
| irq_level | input | 2 | Level of the pending request (0 = most urgent) |
| irq_accept | output | 1 | Request may be taken now |
| ps_out | output | 16 | Current status word |

## Verification
The hardest case to reach from the ports is an edge where three things happen at once: an interrupt is being accepted, flag enables are active, and a full write is asserted. Only the full write may win on that edge.

The bench first uses a full write to set I=1 with a chosen level. It then presents a more urgent request and confirms `irq_accept` high before the edge. On that same edge it raises every flag enable and the write strobe, and it checks that the written word alone appears afterwards.

A separate scenario shows that a level load and a carry update on one edge do not cancel each other. It also re-presents a request at the newly stored level and checks that the request is refused.

// File: rtl/ps_pkg.sv
// Package: shared widths, layout constants and the condition-code type for
// the processor status unit. Assumes an 8-bit datapath and 16-bit addresses.
package ps_pkg;
    localparam int RP_W    = 5;   // bank pointer width
    localparam int SEL_W   = 3;   // register selector width
    localparam int LVL_W   = 2;   // interrupt level width
    localparam int DATA_W  = 8;   // ALU result width
    localparam int PS_W    = 16;  // status word width
    localparam int ADDR_W  = 16;  // register address width
    localparam int NUM_AFL = 5;   // arithmetic flags with own enables

    // Indices of the arithmetic flags inside the enable vector
    localparam int FL_C = 0;
    localparam int FL_V = 1;
    localparam int FL_Z = 2;
    localparam int FL_N = 3;
    localparam int FL_H = 4;

    localparam logic [ADDR_W-1:0] REG_PAGE = 16'h0100;
    localparam int RP_LSB = PS_W - RP_W;
    // Bits that a full write may set; bits between the pointer and CCR read 0
    localparam logic [PS_W-1:0] PS_WMASK = {{RP_W{1'b1}}, {(PS_W-RP_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};
    localparam logic [LVL_W-1:0] IL_RESET = '1;

    typedef struct packed {
        logic             h;
        logic             ie;
        logic [LVL_W-1:0] il;
        logic             n;
        logic             z;
        logic             v;
        logic             c;
    } ccr_t;
endpackage

// File: rtl/ps_flag_next.sv
// Module: next-value logic for the five arithmetic flags.
// Computes each flag's candidate from the ALU inputs and selects it only when
// that flag's enable is set. Assumes vector index order H,N,Z,V,C = 4..0.
module ps_flag_next
    import ps_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0]      result,
    input  logic               half_c,
    input  logic               carry,
    input  logic               ovf,
    input  logic [NUM_AFL-1:0] we,
    input  logic [NUM_AFL-1:0] cur,
    output logic [NUM_AFL-1:0] nxt
);
    logic [NUM_AFL-1:0] cand;

    // Candidate flag values derived from the ALU outputs
    always_comb begin
        cand       = '0;
        cand[FL_H] = half_c;
        cand[FL_N] = result[DW-1];
        cand[FL_Z] = (result == '0);
        cand[FL_V] = ovf;
        cand[FL_C] = carry;
    end

    // One enable-controlled select per flag
    for (genvar i = 0; i < NUM_AFL; i++) begin : g_sel
        assign nxt[i] = we[i] ? cand[i] : cur[i];
    end
endmodule

// File: rtl/ps_bank_addr.sv
// Module: maps bank pointer and register selector onto a register address.
// Address = PAGE + (pointer * 2**SW) + selector. Assumes the slot range fits
// inside the page without carry into the page bits.
module ps_bank_addr #(
    parameter int               PW   = 5,
    parameter int               SW   = 3,
    parameter int               AW   = 16,
    parameter logic [AW-1:0]    PAGE = 16'h0100
) (
    input  logic [PW-1:0] rp,
    input  logic [SW-1:0] sel,
    output logic [AW-1:0] addr
);
    localparam int IDX_W = PW + SW;
    logic [IDX_W-1:0] slot;

    // Concatenate pointer and selector into the offset within the page
    always_comb slot = {rp, sel};

    // Offset the slot into the fixed register page
    always_comb addr = PAGE + AW'(slot);
endmodule

// File: rtl/ps_irq_gate.sv
// Module: interrupt acceptance check. A request is taken only when enabled
// and strictly more urgent (numerically lower) than the current level.
// Purely combinational; the caller stores the new level.
module ps_irq_gate #(
    parameter int LW = 2
) (
    input  logic          req,
    input  logic [LW-1:0] lvl,
    input  logic          ie,
    input  logic [LW-1:0] cur_il,
    output logic          accept
);
    // Accept when enabled, requested and strictly more urgent
    always_comb accept = req && ie && (lvl < cur_il);
endmodule

// File: rtl/proc_status_unit.sv
// Module: processor status register with bank addressing and interrupt gate.
// Holds bank pointer and condition codes, applies ALU flag updates, level
// loads on accepted interrupts and full writes (full write wins). Assumes a
// synchronous active-low reset and a single clock.
module proc_status_unit
    import ps_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ps_wr_en,
    input  logic [PS_W-1:0]     ps_wr_data,
    input  logic [DATA_W-1:0]   alu_result,
    input  logic                alu_half_carry,
    input  logic                alu_carry,
    input  logic                alu_ovf,
    input  logic [NUM_AFL-1:0]  flag_we,
    input  logic [SEL_W-1:0]    op_sel,
    output logic [ADDR_W-1:0]   reg_addr,
    input  logic                irq_req,
    input  logic [LVL_W-1:0]    irq_level,
    output logic                irq_accept,
    output logic [PS_W-1:0]     ps_out
);
    logic [PS_W-1:0]    ps_q, ps_d;
    logic [RP_W-1:0]    rp;
    ccr_t               ccr, ccr_d;
    logic [NUM_AFL-1:0] afl_cur, afl_nxt;

    // Field views of the stored word
    always_comb begin
        rp  = ps_q[PS_W-1:RP_LSB];
        ccr = ccr_t'(ps_q[DATA_W-1:0]);
    end

    // Pack the arithmetic flags in enable-vector order
    always_comb begin
        afl_cur       = '0;
        afl_cur[FL_H] = ccr.h;
        afl_cur[FL_N] = ccr.n;
        afl_cur[FL_Z] = ccr.z;
        afl_cur[FL_V] = ccr.v;
        afl_cur[FL_C] = ccr.c;
    end

    ps_flag_next #(.DW(DATA_W)) u_flags (
        .result (alu_result),
        .half_c (alu_half_carry),
        .carry  (alu_carry),
        .ovf    (alu_ovf),
        .we     (flag_we),
        .cur    (afl_cur),
        .nxt    (afl_nxt)
    );

    ps_irq_gate #(.LW(LVL_W)) u_irq (
        .req    (irq_req),
        .lvl    (irq_level),
        .ie     (ccr.ie),
        .cur_il (ccr.il),
        .accept (irq_accept)
    );

    ps_bank_addr #(.PW(RP_W), .SW(SEL_W), .AW(ADDR_W), .PAGE(REG_PAGE)) u_addr (
        .rp   (rp),
        .sel  (op_sel),
        .addr (reg_addr)
    );

    // Next status word: flags, then level load, full write overriding both
    always_comb begin
        ccr_d    = ccr;
        ccr_d.h  = afl_nxt[FL_H];
        ccr_d.n  = afl_nxt[FL_N];
        ccr_d.z  = afl_nxt[FL_Z];
        ccr_d.v  = afl_nxt[FL_V];
        ccr_d.c  = afl_nxt[FL_C];
        if (irq_accept) ccr_d.il = irq_level;
        ps_d = {rp, {(PS_W-RP_W-DATA_W){1'b0}}, ccr_d};
        if (ps_wr_en) ps_d = ps_wr_data & PS_WMASK;
    end

    // Status register with synchronous reset to pointer 0, level 3
    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= {{(PS_W-DATA_W){1'b0}}, 2'b00, IL_RESET, 4'b0000};
        else        ps_q <= ps_d;
    end

    assign ps_out = ps_q;

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ps_wr_en |=> ps_out == ($past(ps_wr_data) & PS_WMASK)); // R11
    AST_IL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && !ps_wr_en) |=> ps_out[5:4] == $past(irq_level)); // R10
    AST_IE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_wr_en |=> $stable(ps_out[6])); // R10
    AST_C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_wr_en && !flag_we[FL_C]) |=> $stable(ps_out[0])); // R8
    AST_ACCEPT_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> (irq_req && ps_out[6] && ps_out[5:4] != 2'b00)); // R9
    AST_ADDR_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr - REG_PAGE) < 16'd256); // R3
    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ps_wr_en) |-> ps_out[10:8] == 3'b000); // R2
endmodule

// File: tb/tb_proc_status_unit.sv
module tb_proc_status_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ps_wr_en = 0;
    logic [15:0] ps_wr_data = 0;
    logic [7:0]  alu_result = 0;
    logic        alu_half_carry = 0, alu_carry = 0, alu_ovf = 0;
    logic [4:0]  flag_we = 0;
    logic [2:0]  op_sel = 0;
    logic [15:0] reg_addr;
    logic        irq_req = 0;
    logic [1:0]  irq_level = 0;
    logic        irq_accept;
    logic [15:0] ps_out;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    proc_status_unit dut (
        .clk(clk), .rst_n(rst_n), .ps_wr_en(ps_wr_en), .ps_wr_data(ps_wr_data),
        .alu_result(alu_result), .alu_half_carry(alu_half_carry),
        .alu_carry(alu_carry), .alu_ovf(alu_ovf), .flag_we(flag_we),
        .op_sel(op_sel), .reg_addr(reg_addr), .irq_req(irq_req),
        .irq_level(irq_level), .irq_accept(irq_accept), .ps_out(ps_out)
    );

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ps_wr_en = 0; flag_we = 0; irq_req = 0; irq_level = 0;
        alu_result = 0; alu_half_carry = 0; alu_carry = 0; alu_ovf = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic write_ps(logic [15:0] v);
        @(negedge clk);
        ps_wr_en = 1; ps_wr_data = v;
        step();
        ps_wr_en = 0;
    endtask

    task automatic t_reset();
        check("R1 reset word", ps_out, 16'h0030);
        @(negedge clk); irq_req = 1; irq_level = 0; #1;
        check("R9 I=0 blocks request", {15'd0, irq_accept}, 16'd0);
        idle();
    endtask

    task automatic t_write();
        write_ps(16'hFFFF);
        check("R2 gap bits read zero", ps_out, 16'hF8FF);
        write_ps(16'h5AA5);
        check("R2 mixed pattern", ps_out, 16'h58A5);
    endtask

    task automatic t_addr();
        int rps[4] = '{0, 1, 17, 31};
        foreach (rps[k]) begin
            write_ps(16'(rps[k] << 11));
            for (int s = 0; s < 8; s++) begin
                @(negedge clk); op_sel = 3'(s); #1;
                check("R3 register address", reg_addr, 16'(16'h0100 + 8*rps[k] + s));
            end
        end
    endtask

    task automatic t_flags();
        write_ps(16'h0030);
        @(negedge clk);
        flag_we = 5'b11111; alu_result = 8'h80; alu_half_carry = 1; alu_carry = 1; alu_ovf = 0;
        step();
        check("R4 R5 R6 R7 set H N C", ps_out, 16'h00B9);
        @(negedge clk);
        alu_result = 8'h00; alu_half_carry = 0; alu_carry = 0; alu_ovf = 1;
        step();
        check("R4 R5 R6 R7 set Z V clear H N C", ps_out, 16'h0036);
        idle();
    endtask

    task automatic t_hold();
        @(negedge clk);
        flag_we = 5'b00001; alu_result = 8'h80; alu_half_carry = 1; alu_carry = 1; alu_ovf = 0;
        step();
        check("R8 only C follows", ps_out, 16'h0037);
        @(negedge clk);
        flag_we = 5'b00000; alu_result = 8'h00; alu_half_carry = 0; alu_carry = 0; alu_ovf = 0;
        step();
        check("R8 no enable no change", ps_out, 16'h0037);
        idle();
    endtask

    task automatic t_irq();
        write_ps(16'h0060);
        @(negedge clk); irq_req = 1; irq_level = 2; #1;
        check("R9 equal level refused", {15'd0, irq_accept}, 16'd0);
        irq_level = 3; #1;
        check("R9 lower urgency refused", {15'd0, irq_accept}, 16'd0);
        irq_req = 0; irq_level = 1; #1;
        check("R9 no request", {15'd0, irq_accept}, 16'd0);
        irq_req = 1; #1;
        check("R9 more urgent accepted", {15'd0, irq_accept}, 16'd1);
        step();
        check("R10 level loaded I kept", ps_out, 16'h0050);
        #1;
        check("R10 same level now refused", {15'd0, irq_accept}, 16'd0);
        @(negedge clk); irq_level = 0; #1;
        check("R9 level 0 accepted", {15'd0, irq_accept}, 16'd1);
        step();
        check("R10 level 0 stored", ps_out, 16'h0040);
        idle();
        write_ps(16'h0070);
        @(negedge clk); irq_req = 1; irq_level = 2; flag_we = 5'b00001; alu_carry = 1;
        step();
        check("R10 level load with carry update", ps_out, 16'h0061);
        idle();
    endtask

    task automatic t_priority();
        write_ps(16'h0070);
        @(negedge clk);
        irq_req = 1; irq_level = 0; flag_we = 5'b11111; alu_result = 8'h00;
        alu_carry = 1; alu_ovf = 1; alu_half_carry = 1;
        ps_wr_en = 1; ps_wr_data = 16'h0830; #1;
        check("R11 accept seen before edge", {15'd0, irq_accept}, 16'd1);
        step();
        check("R11 write overrides level and flags", ps_out, 16'h0830);
        idle();
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        t_reset();
        t_write();
        t_addr();
        t_flags();
        t_hold();
        t_irq();
        t_priority();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule